// File: doc/BRIEF.md
# Bus Master Grant Sequencer

This block decides which of several bus-master slots owns a shared bus, and drives the master-acknowledge grant outputs. Each slot raises a request line. On a rising edge of the bus clock the sequencer samples the requests and grants the bus to one slot. A slot chosen on an edge sees its grant from that edge on, so it can start driving on the falling edge that follows. The grant then stays up until the edge at which the owner's request is sampled low.

A two-bit mode input sets the form of the grant outputs. With mode `2'b00`, only four slots take part and each slot has its own grant bit. With any other mode value, every slot takes part and the same outputs carry the binary number of the granted slot, which an external decoder turns into per-slot grants.

When another eligible slot or a memory refresh wants the bus, the sequencer takes the grant away while the owner still holds its request. The owner then has a bounded window to let go. If it keeps its request past that window, the sequencer flags a timeout, reclaims the bus, and leaves that slot out of arbitration until it drops its request. A refresh request wins over all masters. Masters are served in rotating order.

Top module: `bus_grant_seq`

## Requirements
- R1: While `rst_n` is low, no slot is granted (`grant_o` is 0 in mode `2'b00` and 4'b1111 in any other mode), and `refresh_gnt_o` and `timeout_o` are low.
- R2: In mode `2'b00`, `grant_o[i]` is high exactly while slot i owns the bus and at most one bit is set. Only slots 0 to 3 can win, so a request from slot 4 or higher never produces a grant.
- R3: In any mode other than `2'b00`, `grant_o` holds the binary number of the owning slot, and 4'b1111 means no slot is granted. All `NUM_SLOTS` slots can win.
- R4: When the bus is idle, a slot whose request is sampled high at an edge is granted from that edge on. The grant stays high until the edge at which the owner's request is sampled low, where it drops. The next arbitration takes place one edge later.
- R5: While an owner keeps its request and another eligible slot or the refresh input is requesting, the grant is withdrawn only after it has been high for `MIN_HOLD` cycles (default 2). It is withdrawn on the very next edge after that.
- R6: After a withdrawal, if the owner's request is still sampled high at `REL_LIMIT` consecutive edges, `timeout_o` is high for exactly one cycle after the last of them. The bus returns to idle, and that slot is left out of arbitration until its request is sampled low. If the owner drops its request at or before that last edge, no timeout occurs.
- R7: A refresh request seen while the bus is idle wins over any slot request. `refresh_gnt_o` stays high until the refresh request is sampled low, and no slot grant is active at the same time.
- R8: Among eligible requests, the winner is the first slot after the most recently granted slot, in ascending order with wraparound. After reset the search starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Grant form: `2'b00` one-hot over four slots, any other value encoded |
| req_i | input | NUM_SLOTS | Per-slot bus request, active high |
| refresh_req_i | input | 1 | Memory refresh request, active high |
| grant_o | output | GNT_W (4) | Per-slot grants or the encoded slot number |
| refresh_gnt_o | output | 1 | Bus granted to refresh |
| timeout_o | output | 1 | One-cycle pulse when an owner misses its release window |

## Verification
The hardest case to reach is the release timeout followed by exclusion. Getting there needs a preemption first. The owner must then keep its request through every edge of the window while a competitor is still waiting. After the window, the stale request must be shown to lose against a clean one. The stimulus starts two encoded-mode slots together, leaves the preempted one asserted for the whole window, and checks the pulse edge by edge. It then drops the competitor and shows that the banned slot stays ungranted until its request has gone low once. A second case drops the request exactly on the last edge of the window, to check that no timeout fires at that boundary.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OWN     = 2'd1,
        ST_RECLAIM = 2'd2,
        ST_REFRESH = 2'd3
    } bgs_state_e;

    localparam logic [1:0] MODE_ONEHOT = 2'b00;

endpackage

// File: rtl/bgs_rr_pick.sv
module bgs_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     mask_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    // Search starts one past the last winner and wraps around.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int k = 1; k <= N; k++) begin
            if (!vld_o && mask_i[(int'(last_i) + k) % N]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'((int'(last_i) + k) % N);
            end
        end
    end

endmodule

// File: rtl/bgs_grant_fmt.sv
module bgs_grant_fmt #(
    parameter int IDX_W = 3,
    parameter int GNT_W = 4
) (
    input  logic             onehot_i,
    input  logic             vld_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [GNT_W-1:0] gnt_o
);

    always_comb begin
        if (onehot_i) begin
            gnt_o = vld_i ? (GNT_W'(1) << idx_i) : '0;
        end else begin
            gnt_o = vld_i ? GNT_W'(idx_i) : '1;
        end
    end

endmodule

// File: rtl/bus_grant_seq.sv
module bus_grant_seq
    import bgs_pkg::*;
#(
    parameter int NUM_SLOTS    = 8,
    parameter int ONEHOT_SLOTS = 4,
    parameter int MIN_HOLD     = 2,
    parameter int REL_LIMIT    = 16,
    localparam int IDX_W       = $clog2(NUM_SLOTS),
    localparam int ENC_W       = $clog2(NUM_SLOTS + 1),
    localparam int GNT_W       = (ENC_W > ONEHOT_SLOTS) ? ENC_W : ONEHOT_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic                 refresh_req_i,
    output logic [GNT_W-1:0]     grant_o,
    output logic                 refresh_gnt_o,
    output logic                 timeout_o
);

    localparam int CNT_W     = $clog2(REL_LIMIT + MIN_HOLD + 1);
    localparam int HOLD_LAST = MIN_HOLD - 1;
    localparam int REL_LAST  = REL_LIMIT - 1;

    typedef struct packed {
        bgs_state_e       st;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] last;
        logic [CNT_W-1:0] cnt;
        logic             ban_vld;
        logic [IDX_W-1:0] ban_slot;
        logic             tmo;
    } ctl_t;

    ctl_t s_q, s_d;

    logic                 onehot;
    logic [NUM_SLOTS-1:0] elig;
    logic                 pick_vld;
    logic [IDX_W-1:0]     pick_idx;
    logic                 owner_req;
    logic                 contend;

    assign onehot = (mode_i == MODE_ONEHOT);

    // Per-slot eligibility: request, allowed by mode, not banned.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_elig
        assign elig[i] = req_i[i]
                       && (!onehot || (i < ONEHOT_SLOTS))
                       && !(s_q.ban_vld && (s_q.ban_slot == IDX_W'(i)));
    end

    bgs_rr_pick #(
        .N     (NUM_SLOTS),
        .IDX_W (IDX_W)
    ) u_pick (
        .mask_i (elig),
        .last_i (s_q.last),
        .vld_o  (pick_vld),
        .idx_o  (pick_idx)
    );

    assign owner_req = req_i[s_q.owner];
    assign contend   = (|(elig & ~(NUM_SLOTS'(1) << s_q.owner))) || refresh_req_i;

    always_comb begin
        s_d     = s_q;
        s_d.tmo = 1'b0;

        if (s_q.ban_vld && !req_i[s_q.ban_slot]) begin
            s_d.ban_vld = 1'b0;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (refresh_req_i) begin
                    s_d.st = ST_REFRESH;
                end else if (pick_vld) begin
                    s_d.st    = ST_OWN;
                    s_d.owner = pick_idx;
                    s_d.last  = pick_idx;
                    s_d.cnt   = '0;
                end
            end
            ST_OWN: begin
                if (!owner_req) begin
                    s_d.st = ST_IDLE;
                end else if (contend && (s_q.cnt >= CNT_W'(HOLD_LAST))) begin
                    s_d.st  = ST_RECLAIM;
                    s_d.cnt = '0;
                end else if (s_q.cnt < CNT_W'(HOLD_LAST)) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RECLAIM: begin
                if (!owner_req) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.cnt == CNT_W'(REL_LAST)) begin
                    s_d.st       = ST_IDLE;
                    s_d.tmo      = 1'b1;
                    s_d.ban_vld  = 1'b1;
                    s_d.ban_slot = s_q.owner;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_REFRESH: begin
                if (!refresh_req_i) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.owner    <= '0;
            s_q.last     <= IDX_W'(NUM_SLOTS - 1);
            s_q.cnt      <= '0;
            s_q.ban_vld  <= 1'b0;
            s_q.ban_slot <= '0;
            s_q.tmo      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    bgs_grant_fmt #(
        .IDX_W (IDX_W),
        .GNT_W (GNT_W)
    ) u_fmt (
        .onehot_i (onehot),
        .vld_i    (s_q.st == ST_OWN),
        .idx_i    (s_q.owner),
        .gnt_o    (grant_o)
    );

    assign refresh_gnt_o = (s_q.st == ST_REFRESH);
    assign timeout_o     = s_q.tmo;

endmodule

// File: rtl/bus_grant_seq_chk.sv
module bgs_checker #(
    parameter int NUM_SLOTS    = 8,
    parameter int ONEHOT_SLOTS = 4,
    parameter int GNT_W        = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode_i,
    input logic [NUM_SLOTS-1:0] req_i,
    input logic                 refresh_req_i,
    input logic [GNT_W-1:0]     grant_o,
    input logic                 refresh_gnt_o,
    input logic                 timeout_o
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic                 onehot;
    logic                 g_any;
    logic [GNT_W-1:0]     g_idx;
    logic                 g_req_now;
    logic                 g_req_prev;
    logic [NUM_SLOTS-1:0] req_q;

    assign onehot = (mode_i == 2'b00);

    always_comb begin
        g_any = onehot ? (|grant_o) : (grant_o != '1);
        g_idx = onehot ? '0 : grant_o;
        if (onehot) begin
            for (int i = 0; i < GNT_W; i++) begin
                if (grant_o[i]) g_idx = GNT_W'(i);
            end
        end
        g_req_now  = (int'(g_idx) < NUM_SLOTS) ? req_i[g_idx[IDX_W-1:0]] : 1'b0;
        g_req_prev = (int'(g_idx) < NUM_SLOTS) ? req_q[g_idx[IDX_W-1:0]] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // R2: one-hot form never shows two grants or a slot above the four
    p_onehot_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        onehot |-> ($onehot0(grant_o) && ((grant_o >> ONEHOT_SLOTS) == '0)));

    // R3: encoded form is either the idle code or a real slot number
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !onehot |-> ((grant_o == '1) || (int'(grant_o) < NUM_SLOTS)));

    // R4: a fresh grant goes only to a slot that was requesting
    p_new_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && !$past(g_any) && $stable(mode_i)) |-> g_req_prev);

    // R4: owner's request sampled low removes the grant at that edge
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_any && !g_req_now && !refresh_gnt_o) |=> (!g_any || !$stable(mode_i)));

    // R7: refresh grant and slot grant never coexist
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(refresh_gnt_o && g_any));

    // R7: refresh grant holds while refresh is still requested
    p_refresh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_gnt_o && refresh_req_i) |=> refresh_gnt_o);

    // R6: timeout is a single-cycle pulse
    p_tmo_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    // R6: timeout only while the bus is reclaimed
    p_tmo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!g_any && !refresh_gnt_o));

endmodule

bind bus_grant_seq bgs_checker #(
    .NUM_SLOTS    (NUM_SLOTS),
    .ONEHOT_SLOTS (ONEHOT_SLOTS),
    .GNT_W        (GNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .req_i         (req_i),
    .refresh_req_i (refresh_req_i),
    .grant_o       (grant_o),
    .refresh_gnt_o (refresh_gnt_o),
    .timeout_o     (timeout_o)
);

// File: tb/bus_grant_seq_tb.sv
module bus_grant_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 8;
    localparam int HOLD       = 2;
    localparam int RL         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [NS-1:0] req_i = '0;
    logic          refresh_req_i = 1'b0;
    logic [3:0]    grant_o;
    logic          refresh_gnt_o;
    logic          timeout_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] g;
        logic       rg;
        logic       to;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    bus_grant_seq #(
        .NUM_SLOTS (NS),
        .MIN_HOLD  (HOLD),
        .REL_LIMIT (RL)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .req_i         (req_i),
        .refresh_req_i (refresh_req_i),
        .grant_o       (grant_o),
        .refresh_gnt_o (refresh_gnt_o),
        .timeout_o     (timeout_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(string tag, logic [3:0] eg, logic erg, logic eto);
        checks++;
        if (grant_o !== eg || refresh_gnt_o !== erg || timeout_o !== eto) begin
            errors++;
            $display("FAIL %s cyc %0d: grant %h rgnt %b tmo %b, expected grant %h rgnt %b tmo %b",
                     tag, cyc, grant_o, refresh_gnt_o, timeout_o, eg, erg, eto);
        end
    endtask

    // Driver side: queue an expectation d cycles after the current one.
    task automatic expect_at(int d, logic [3:0] g, logic rg, logic to, string tag);
        exp_t e;
        e.at = cyc + d; e.g = g; e.rg = rg; e.to = to; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compare queued items at the falling edge of their cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
                cur = exp_q.pop_front();
                if (cur.at < cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s: item for cyc %0d missed, now %0d, expected %0d",
                             cur.tag, cur.at, cyc, cur.at);
                end else begin
                    compare(cur.tag, cur.g, cur.rg, cur.to);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b;
        // R1: reset state in both grant forms
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset onehot", 4'b0000, 1'b0, 1'b0);
        req_i = 8'hFF;
        refresh_req_i = 1'b1;
        mode_i = 2'b10;
        @(posedge clk);
        @(negedge clk);
        compare("R1 reset encoded", 4'b1111, 1'b0, 1'b0);
        req_i = '0;
        refresh_req_i = 1'b0;
        mode_i = 2'b00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        wait_to(cyc + 2);

        // R4/R2/R8: single request, slot 0 first after reset
        b = cyc;
        expect_at(1, 4'b0001, 0, 0, "R4 grant on idle");
        expect_at(2, 4'b0001, 0, 0, "R2 onehot hold");
        expect_at(3, 4'b0001, 0, 0, "R4 hold");
        expect_at(4, 4'b0000, 0, 0, "R4 release");
        req_i = 8'b0000_0001;
        wait_to(b + 3);
        req_i = '0;
        wait_to(b + 6);

        // R2: slot 4 cannot win in one-hot mode
        b = cyc;
        expect_at(1, 4'b0000, 0, 0, "R2 slot4 ignored");
        expect_at(3, 4'b0000, 0, 0, "R2 slot4 ignored late");
        req_i = 8'b0001_0000;
        wait_to(b + 3);
        req_i = '0;
        wait_to(b + 5);

        // R8/R5: slots 0 and 2, last was 0 so 2 wins, then preempted
        b = cyc;
        expect_at(1, 4'b0100, 0, 0, "R8 rotate to slot2");
        expect_at(2, 4'b0100, 0, 0, "R5 min hold");
        expect_at(3, 4'b0000, 0, 0, "R5 preempt");
        expect_at(4, 4'b0000, 0, 0, "R6 early release no timeout");
        expect_at(5, 4'b0001, 0, 0, "R8 slot0 next");
        expect_at(6, 4'b0000, 0, 0, "R4 release slot0");
        req_i = 8'b0000_0101;
        wait_to(b + 3);
        req_i = 8'b0000_0001;
        wait_to(b + 5);
        req_i = '0;
        wait_to(b + 8);

        // R3: encoded mode, slot 7
        b = cyc;
        mode_i = 2'b01;
        expect_at(0, 4'b1111, 0, 0, "R3 idle code");
        expect_at(1, 4'd7, 0, 0, "R3 encoded slot7");
        expect_at(2, 4'd7, 0, 0, "R3 encoded hold");
        expect_at(3, 4'b1111, 0, 0, "R3 idle after release");
        req_i = 8'b1000_0000;
        wait_to(b + 2);
        req_i = '0;
        wait_to(b + 5);

        // R6: slots 5 and 6, slot 5 preempted and holds past the window
        b = cyc;
        expect_at(1, 4'd5, 0, 0, "R8 slot5 after 7");
        expect_at(3, 4'b1111, 0, 0, "R5 preempt encoded");
        expect_at(RL + 2, 4'b1111, 0, 0, "R6 no early timeout");
        expect_at(RL + 3, 4'b1111, 0, 1, "R6 timeout pulse");
        expect_at(RL + 4, 4'd6, 0, 0, "R6 reclaimed to slot6");
        expect_at(RL + 5, 4'b1111, 0, 0, "R4 slot6 release");
        expect_at(RL + 6, 4'b1111, 0, 0, "R6 banned slot5");
        expect_at(RL + 7, 4'b1111, 0, 0, "R6 banned slot5 late");
        expect_at(RL + 8, 4'b1111, 0, 0, "R6 ban clears");
        expect_at(RL + 9, 4'd5, 0, 0, "R6 slot5 after ban");
        expect_at(RL + 10, 4'b1111, 0, 0, "R4 slot5 release");
        req_i = 8'b0110_0000;
        wait_to(b + RL + 4);
        req_i = 8'b0010_0000;
        wait_to(b + RL + 7);
        req_i = '0;
        wait_to(b + RL + 8);
        req_i = 8'b0010_0000;
        wait_to(b + RL + 9);
        req_i = '0;
        wait_to(b + RL + 12);

        // R6 boundary: release on the last window edge, no timeout
        b = cyc;
        mode_i = 2'b00;
        expect_at(1, 4'b0010, 0, 0, "R8 slot1 in onehot");
        expect_at(3, 4'b0000, 0, 0, "R5 preempt by slot3");
        expect_at(RL + 2, 4'b0000, 0, 0, "R6 window running");
        expect_at(RL + 3, 4'b0000, 0, 0, "R6 last edge release no timeout");
        expect_at(RL + 4, 4'b1000, 0, 0, "R8 slot3 next");
        expect_at(RL + 5, 4'b0000, 0, 0, "R4 slot3 release");
        req_i = 8'b0000_1010;
        wait_to(b + RL + 2);
        req_i = 8'b0000_1000;
        wait_to(b + RL + 4);
        req_i = '0;
        wait_to(b + RL + 7);

        // R7: refresh wins at idle, then preempts an owner
        b = cyc;
        expect_at(1, 4'b0000, 1, 0, "R7 refresh wins");
        expect_at(2, 4'b0000, 1, 0, "R7 refresh hold");
        expect_at(3, 4'b0000, 0, 0, "R7 refresh release");
        expect_at(4, 4'b0001, 0, 0, "R8 slot0 after 3");
        expect_at(5, 4'b0001, 0, 0, "R5 hold vs refresh");
        expect_at(6, 4'b0000, 0, 0, "R7 refresh preempts");
        expect_at(7, 4'b0000, 0, 0, "R7 owner releasing");
        expect_at(8, 4'b0000, 1, 0, "R7 refresh granted");
        expect_at(9, 4'b0000, 0, 0, "R7 refresh done");
        req_i = 8'b0000_0001;
        refresh_req_i = 1'b1;
        wait_to(b + 2);
        refresh_req_i = 1'b0;
        wait_to(b + 4);
        refresh_req_i = 1'b1;
        wait_to(b + 6);
        req_i = '0;
        wait_to(b + 8);
        refresh_req_i = 1'b0;
        wait_to(b + 11);

        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule